// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a receive-only slave on a two-wire serial bus. A host uses it to load a small bank of 8-bit configuration registers. The block oversamples the clock and data lines with the system clock and detects start and stop conditions. It shifts in bytes most-significant bit first on rising serial-clock edges.

Every transaction has a fixed shape of ten bytes: an address byte, a command byte, a count byte and then seven data bytes. The address byte is compared with a fixed slave address. On a match, every byte of the frame is acknowledged and the data bytes land in registers 0 to 6 in the order they arrive. On a mismatch, the block stays silent and writes nothing. The command and count bytes only hold their places in the frame.

Each register has a defined value after reset, so the surrounding logic works even if no write ever happens. The registers are presented as one flat parallel output bus.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register i (i = 0..6) holds the value {i[3:0], 4'hF}, except that bit 7 of register 6 is 0. The acknowledge drive `sda_oe` is 0.
- R2: In a frame with address byte 8'hD2, data bytes 0..6 (frame bytes 4..10) are loaded into registers 0..6 in arrival order. Each byte is received MSB first, and register i appears at `cfg_o[8*i+7 : 8*i]`.
- R3: A frame whose address byte is anything other than 8'hD2 leaves every register unchanged.
- R4: The values of the command byte and the count byte (frame bytes 2 and 3) have no effect on any register.
- R5: In a matched frame, the slave pulls the data line low (`sda_oe` = 1) during the ninth clock of each of the ten bytes. It asserts this drive only while the serial clock is low.
- R6: After a mismatched address byte, the slave never drives the data line, for that byte or any later byte of the frame.
- R7: Bit 7 of register 6 is reserved and always reads 0, whatever value the host writes.
- R8: If a stop or a repeated start ends a matched frame early, the data bytes already received stay written and the other registers keep their values. After a repeated start, the next frame is decoded from its address byte.
- R9: Bytes after the tenth byte of a frame are not acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the data line is pulled low (acknowledge) |
| cfg_o | output | 56 | Flat register bank, register i at bits 8*i+7 down to 8*i |

## Verification
The bench aims at the frame edges. These include an address that differs from the slave address in only its lowest or highest bit; a design comparing fewer bits would accept that frame and overwrite registers. It also cuts frames short with a stop or a repeated start and adds an eleventh byte, which catch an engine that drops partial data, fails to resynchronise on the new address, or acknowledges and stores bytes past the frame end. It writes all ones to the reserved bit and varies the command and count values, so a register file that lets the reserved bit through, or that counts the header bytes as data, shows up as shifted or wrong register contents.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int BYTE_W     = 8;
    localparam int HDR_BYTES  = 3;
    localparam int DEF_NREGS  = 7;
    localparam logic [7:0] DEF_ADDR = 8'hD2;
    localparam int RSVD_REG   = 6;
    localparam int RSVD_BIT   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_WAIT
    } rx_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    function automatic logic [7:0] rsvd_mask(input int idx);
        logic [7:0] m;
        m = 8'h00;
        if (idx == RSVD_REG) m[RSVD_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] default_val(input int idx);
        logic [7:0] v;
        v = {idx[3:0], 4'hF};
        return v & ~rsvd_mask(idx);
    endfunction

endpackage

// File: rtl/line_sampler.sv
module line_sampler
    import cfgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [S-1:0] scl_q;
    logic [S-1:0] sda_q;
    logic         scl_prev;
    logic         sda_prev;
    logic         scl_s;
    logic         sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[S-2:0], scl_i};
            sda_q    <= {sda_q[S-2:0], sda_i};
            scl_prev <= scl_q[S-1];
            sda_prev <= sda_q[S-1];
        end
    end

    assign scl_s = scl_q[S-1];
    assign sda_s = sda_q[S-1];

    always_comb begin
        ev.start = scl_s && scl_prev && sda_prev && !sda_s;
        ev.stop  = scl_s && scl_prev && !sda_prev && sda_s;
        ev.rise  = scl_s && !scl_prev;
        ev.fall  = !scl_s && scl_prev;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/byte_engine.sv
module byte_engine
    import cfgs_pkg::*;
#(
    parameter int         N_REGS = DEF_NREGS,
    parameter logic [7:0] ADDR   = DEF_ADDR,
    localparam int FRAME = HDR_BYTES + N_REGS,
    localparam int CNTW  = $clog2(FRAME + 1),
    localparam int IDXW  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  line_ev_t        ev,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            ack_oe,
    output logic            addr_ok
);

    rx_state_t        state;
    logic [2:0]       bitcnt;
    logic [CNTW-1:0]  bidx;
    logic [6:0]       shreg;
    logic [7:0]       full;

    assign full = {shreg, ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            bidx    <= '0;
            shreg   <= '0;
            ack_oe  <= 1'b0;
            addr_ok <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state   <= ST_RX;
                bitcnt  <= '0;
                bidx    <= '0;
                ack_oe  <= 1'b0;
                addr_ok <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                ack_oe  <= 1'b0;
                addr_ok <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg <= full[6:0];
                            if (bitcnt == 3'd7) begin
                                bitcnt <= '0;
                                if (bidx == '0) begin
                                    if (full == ADDR) begin
                                        addr_ok <= 1'b1;
                                        state   <= ST_ACK;
                                    end else begin
                                        state   <= ST_WAIT;
                                    end
                                end else begin
                                    state <= ST_ACK;
                                    if (bidx >= CNTW'(HDR_BYTES)) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= IDXW'(bidx - CNTW'(HDR_BYTES));
                                        wr_data <= full;
                                    end
                                end
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            if (!ack_oe) begin
                                ack_oe <= 1'b1;
                            end else begin
                                ack_oe <= 1'b0;
                                if (bidx == CNTW'(FRAME - 1)) begin
                                    state <= ST_WAIT;
                                end else begin
                                    state <= ST_RX;
                                    bidx  <= bidx + CNTW'(1);
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/reg_file.sv
module reg_file
    import cfgs_pkg::*;
#(
    parameter int N_REGS = DEF_NREGS,
    localparam int IDXW  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [7:0]                 wr_data,
    output logic [N_REGS*BYTE_W-1:0]   cfg_o
);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        logic [7:0] r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= default_val(i);
            end else if (wr_en && wr_idx == IDXW'(i)) begin
                r <= wr_data & ~rsvd_mask(i);
            end
        end
        assign cfg_o[i*BYTE_W +: BYTE_W] = r;
    end

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter int         N_REGS      = DEF_NREGS,
    parameter logic [7:0] ADDR        = DEF_ADDR,
    parameter int         SYNC_STAGES = 2,
    localparam int IDXW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [N_REGS*BYTE_W-1:0]  cfg_o
);

    line_ev_t        ev;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;
    logic            addr_ok;

    line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    byte_engine #(.N_REGS(N_REGS), .ADDR(ADDR)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ack_oe  (sda_oe),
        .addr_ok (addr_ok)
    );

    reg_file #(.N_REGS(N_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
    import cfgs_pkg::*;
#(
    parameter int N_REGS = DEF_NREGS
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     scl_i,
    input logic                     sda_oe,
    input logic                     addr_ok,
    input logic [N_REGS*BYTE_W-1:0] cfg_o
);

    function automatic logic [N_REGS*BYTE_W-1:0] def_flat();
        logic [N_REGS*BYTE_W-1:0] v;
        for (int i = 0; i < N_REGS; i++) v[i*BYTE_W +: BYTE_W] = default_val(i);
        return v;
    endfunction

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_o == def_flat()));

    // R3
    no_write_unmatched_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_ok |=> $stable(cfg_o));

    // R5
    ack_on_low_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R6
    silent_unmatched_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> addr_ok);

    if (N_REGS > RSVD_REG) begin : g_rsvd
        // R7
        reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
            cfg_o[RSVD_REG*BYTE_W + RSVD_BIT] == 1'b0);
    end

endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.N_REGS(N_REGS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .addr_ok (addr_ok),
    .cfg_o   (cfg_o)
);

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;

    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_host = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [55:0] cfg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_r [7];
    logic [7:0] fr [16];
    logic       ackv [16];

    assign sda_line = sda_host & ~sda_oe;

    always #2 clk = ~clk;

    cfg_serial_slave u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg)
    );

    function automatic logic [7:0] bmask(input int i);
        return (i == 6) ? 8'h80 : 8'h00;
    endfunction

    function automatic logic [7:0] bdef(input int i);
        logic [7:0] v;
        v = {i[3:0], 4'hF};
        return v & ~bmask(i);
    endfunction

    task automatic cmp(input logic [7:0] act, input logic [7:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; wq();
        scl = 1'b1;      wq();
        sda_host = 1'b0; wq();
        scl = 1'b0;      wq();
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; wq();
        scl = 1'b1;      wq();
        sda_host = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int k = 7; k >= 0; k--) begin
            sda_host = b[k]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0; wq();
        end
        sda_host = 1'b1; wq();
        scl = 1'b1; wq();
        a = sda_line; wq();
        scl = 1'b0; wq();
        ack = !a;
    endtask

    task automatic send_frame(input int nb, input bit stop);
        logic a;
        bus_start();
        for (int i = 0; i < nb; i++) begin
            send_byte(fr[i], a);
            ackv[i] = a;
        end
        if (stop) bus_stop();
    endtask

    function automatic void model_frame(input int nb);
        if (fr[0] == 8'hD2) begin
            for (int i = 3; i < nb && i < 10; i++) exp_r[i-3] = fr[i] & ~bmask(i-3);
        end
    endfunction

    task automatic check_acks(input int nb);
        bit m;
        m = (fr[0] == 8'hD2);
        for (int i = 0; i < nb; i++) begin
            if (i >= 10)
                cmp({7'd0, ackv[i]}, 8'd0, "R9 ack past frame end");
            else if (m)
                cmp({7'd0, ackv[i]}, 8'd1, "R5 ack in ninth clock");
            else
                cmp({7'd0, ackv[i]}, 8'd0, "R6 silent on mismatch");
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 7; i++) cmp(cfg[i*8 +: 8], exp_r[i], tag);
    endtask

    task automatic fill(input logic [7:0] addr, input logic [7:0] c, input logic [7:0] n, input logic [7:0] base);
        fr[0] = addr; fr[1] = c; fr[2] = n;
        for (int i = 3; i < 16; i++) fr[i] = base + 8'(i * 37);
    endtask

    task automatic do_frame(input int nb, input bit stop, input string tag);
        send_frame(nb, stop);
        model_frame(nb);
        check_acks(nb);
        check_regs(tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int r;
        logic [7:0] a;
        int nb;
        bit st;
        r = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 7; i++) exp_r[i] = bdef(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset values and idle acknowledge drive
        check_regs("R1 reset value");
        cmp({7'd0, sda_oe}, 8'd0, "R1 no drive after reset");

        // R2 and R5: directed matched frame
        fr[0] = 8'hD2; fr[1] = 8'h00; fr[2] = 8'h07;
        fr[3] = 8'hA5; fr[4] = 8'h3C; fr[5] = 8'h81; fr[6] = 8'h7E;
        fr[7] = 8'h01; fr[8] = 8'h80; fr[9] = 8'h55;
        do_frame(10, 1'b1, "R2 data load order");

        // R4: different command and count values, new data
        fill(8'hD2, 8'hFF, 8'h00, 8'h11);
        do_frame(10, 1'b1, "R4 header bytes ignored");
        fill(8'hD2, 8'h5A, 8'hC3, 8'h11);
        do_frame(10, 1'b1, "R4 header bytes ignored");

        // R3 and R6: addresses one bit away and a far address
        fill(8'hD3, 8'h00, 8'h07, 8'h99);
        do_frame(10, 1'b1, "R3 mismatch low bit");
        fill(8'h52, 8'h00, 8'h07, 8'h42);
        do_frame(10, 1'b1, "R3 mismatch high bit");
        fill(8'h00, 8'h00, 8'h07, 8'h77);
        do_frame(10, 1'b1, "R3 mismatch zero");

        // R7: all ones into every register
        fr[0] = 8'hD2; fr[1] = 8'h00; fr[2] = 8'h07;
        for (int i = 3; i < 10; i++) fr[i] = 8'hFF;
        do_frame(10, 1'b1, "R7 reserved bit zero");

        // R8: early stop after two data bytes
        fill(8'hD2, 8'h01, 8'h02, 8'h20);
        do_frame(5, 1'b1, "R8 early stop");

        // R8: repeated start mid frame, then a full frame
        fill(8'hD2, 8'h01, 8'h02, 8'h63);
        do_frame(7, 1'b0, "R8 cut by repeated start");
        fill(8'hD2, 8'h09, 8'h08, 8'h0B);
        do_frame(10, 1'b1, "R8 frame after repeated start");

        // R9: eleventh byte
        fill(8'hD2, 8'h00, 8'h07, 8'hE1);
        fr[10] = 8'h00;
        do_frame(11, 1'b1, "R9 byte past frame end");

        // Random frames, R2 and R3
        for (int t = 0; t < 24; t++) begin
            a = ($urandom % 10 < 7) ? 8'hD2 : 8'($urandom);
            if (a == 8'hD2 && t % 5 == 4) a = 8'hD2 ^ (8'h01 << ($urandom % 8));
            fill(a, 8'($urandom), 8'($urandom), 8'($urandom));
            for (int i = 3; i < 11; i++) fr[i] = 8'($urandom);
            nb = ($urandom % 4 == 0) ? 3 + int'($urandom % 9) : 10;
            st = (t == 23) ? 1'b1 : ($urandom % 5 != 0);
            do_frame(nb, st, "R2 R3 random frame");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule